// File: doc/BRIEF.md
# Asynchronous SRAM Cycle Controller

This block sits between a synchronous host and an external asynchronous static RAM of the 128K x 8 class. The host hands it one single-beat read or write at a time through a valid/ready handshake. The controller then drives the active-low chip enable, output enable and write enable strobes, the address bus and the write data bus. Every strobe width, access time and hold time is held for a whole number of clock cycles. These counts are derived from nanosecond parameters and the clock period, always rounded up. A read ends with the captured byte and a one-cycle done pulse. A write ends with a done pulse once the address and data hold time has passed.

A write is timed from the write enable. Chip enable and write enable fall in the same cycle. Write enable rises first. Chip enable, the address and the driven data stay in place for the hold interval, and only then does the cycle release. Output enable stays high for the whole write. When a write follows a read, one cycle with every strobe high is inserted before the data bus is driven. The data bus has a separate output-enable control, so the pad ring or the bench can resolve the bidirectional pins.

Top module: `sram_cyc_ctrl`

## Requirements
- R1: While reset is asserted, and on the first cycle after reset, the three strobes are high (inactive), `mem_dq_oe` is 0, `req_ready` is 1 and `rsp_done` is 0. Reset during an access abandons it at once.
- R2: A read holds chip enable and output enable low and write enable high for RD = max(ceil(70/T), ceil(70/T), ceil(35/T)) cycles, where T is the clock period in ns. The address bus carries the requested address throughout.
- R3: The read byte is sampled at the clock edge that ends the last of the RD cycles. In the following cycle `rsp_done` is 1 for exactly one cycle, and `rsp_rdata` holds the byte.
- R4: A write pulls chip enable and write enable low in the same cycle. Write enable stays low for WL = max(ceil(55/T), ceil(65/T), ceil(30/T)) cycles. Output enable is high whenever write enable is low.
- R5: `mem_dq_oe` is 1 only while chip enable is low and output enable is high. It covers the WL cycles and HOLD = ceil(5/T) further cycles after write enable rises, and chip enable stays low through those hold cycles. `mem_dq_out` equals the request data and does not change while `mem_dq_oe` is 1.
- R6: The address bus does not change while chip enable is low.
- R7: `req_ready` is 0 from the cycle after acceptance for max(RD, CYC) cycles for a read, where CYC = ceil(tcycle/T). For a write it is 0 for max(WL+HOLD, CYC) cycles, plus one when a turnaround is inserted. A request presented while `req_ready` is 0 is ignored and never reaches the memory.
- R8: A write accepted after a read spends its first busy cycle with all strobes high and `mem_dq_oe` at 0. Write enable falls in the second busy cycle. A write that follows a write needs no such cycle.
- R9: A write raises `rsp_done` for one cycle, on the cycle after its last hold cycle. The written byte is then read back unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller can accept a request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Byte address |
| req_wdata | input | 8 | Write data |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 8 | Byte returned by the last read |
| mem_ce_n | output | 1 | Memory chip enable, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_we_n | output | 1 | Memory write enable, active low |
| mem_addr | output | 17 | Memory address bus |
| mem_dq_out | output | 8 | Data driven toward the memory |
| mem_dq_oe | output | 1 | 1 = controller drives the data bus |
| mem_dq_in | input | 8 | Data returned by the memory |

## Verification
A wrong cycle counter in the sequencer shows up as a write enable pulse or read window of the wrong length, one cycle off. It is visible the very cycle the strobe returns high. A stray state decode shows up as output enable low together with write enable, or as the data bus driven while chip enable is high, in the same cycle it happens. A lost read-history flag shows up as a missing turnaround cycle on the first write after a read. A latch that follows the host inputs while the controller is busy moves the address under an active chip enable, and a later read-back then returns the wrong byte.

// File: rtl/sram_cyc_pkg.sv
package sram_cyc_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_TURN  = 3'd1,
    ST_READ  = 3'd2,
    ST_WLOW  = 3'd3,
    ST_WHOLD = 3'd4,
    ST_PAD   = 3'd5
  } seq_state_t;

  // whole cycles needed to cover ns nanoseconds at clk_ns per cycle
  function automatic int ns_to_cyc(input int ns, input int clk_ns);
    return (ns + clk_ns - 1) / clk_ns;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  function automatic int nonzero(input int a);
    return (a < 1) ? 1 : a;
  endfunction

  // pad cycles so a whole access spans at least the cycle time
  function automatic int pad_of(input int cyc, input int used);
    return (cyc > used) ? (cyc - used) : 0;
  endfunction

endpackage

// File: rtl/sram_cyc_seq.sv
module sram_cyc_seq
  import sram_cyc_pkg::*;
#(
  parameter int RD_CYC = 7,
  parameter int WL_CYC = 7,
  parameter int WH_CYC = 1,
  parameter int RD_PAD = 0,
  parameter int WR_PAD = 0,
  parameter int CNT_W  = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  input  logic req_write,
  output logic req_ready,
  output logic accept,
  output logic rd_capture,
  output logic wr_release,
  output logic ce_n,
  output logic oe_n,
  output logic we_n,
  output logic dq_oe
);

  localparam logic [CNT_W-1:0] RD_LAST  = CNT_W'(RD_CYC - 1);
  localparam logic [CNT_W-1:0] WL_LAST  = CNT_W'(WL_CYC - 1);
  localparam logic [CNT_W-1:0] WH_LAST  = CNT_W'(WH_CYC - 1);
  localparam logic [CNT_W-1:0] RDP_LAST = CNT_W'((RD_PAD == 0) ? 0 : RD_PAD - 1);
  localparam logic [CNT_W-1:0] WRP_LAST = CNT_W'((WR_PAD == 0) ? 0 : WR_PAD - 1);

  seq_state_t       st, st_nxt;
  logic [CNT_W-1:0] cnt, cnt_nxt;
  logic             last_rd, last_rd_nxt;
  logic             op_wr, op_wr_nxt;

  // named internal events
  logic wlow_end;
  logic pad_end;

  assign req_ready  = (st == ST_IDLE);
  assign accept     = req_ready && req_valid;
  assign rd_capture = (st == ST_READ)  && (cnt == RD_LAST);
  assign wlow_end   = (st == ST_WLOW)  && (cnt == WL_LAST);
  assign wr_release = (st == ST_WHOLD) && (cnt == WH_LAST);
  assign pad_end    = (st == ST_PAD) && (cnt == (op_wr ? WRP_LAST : RDP_LAST));

  always_comb begin
    st_nxt      = st;
    cnt_nxt     = cnt + 1'b1;
    last_rd_nxt = last_rd;
    op_wr_nxt   = op_wr;
    unique case (st)
      ST_IDLE: begin
        cnt_nxt = '0;
        if (accept) begin
          op_wr_nxt = req_write;
          if (req_write) begin
            st_nxt      = last_rd ? ST_TURN : ST_WLOW;
            last_rd_nxt = 1'b0;
          end else begin
            st_nxt = ST_READ;
          end
        end
      end
      ST_TURN: begin
        cnt_nxt = '0;
        st_nxt  = ST_WLOW;
      end
      ST_READ: begin
        if (rd_capture) begin
          cnt_nxt     = '0;
          last_rd_nxt = 1'b1;
          st_nxt      = (RD_PAD != 0) ? ST_PAD : ST_IDLE;
        end
      end
      ST_WLOW: begin
        if (wlow_end) begin
          cnt_nxt = '0;
          st_nxt  = ST_WHOLD;
        end
      end
      ST_WHOLD: begin
        if (wr_release) begin
          cnt_nxt = '0;
          st_nxt  = (WR_PAD != 0) ? ST_PAD : ST_IDLE;
        end
      end
      ST_PAD: begin
        if (pad_end) begin
          cnt_nxt = '0;
          st_nxt  = ST_IDLE;
        end
      end
      default: begin
        cnt_nxt = '0;
        st_nxt  = ST_IDLE;
      end
    endcase
  end

  // strobes are registered from the next state so the pins never glitch
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      cnt     <= '0;
      last_rd <= 1'b0;
      op_wr   <= 1'b0;
      ce_n    <= 1'b1;
      oe_n    <= 1'b1;
      we_n    <= 1'b1;
      dq_oe   <= 1'b0;
    end else begin
      st      <= st_nxt;
      cnt     <= cnt_nxt;
      last_rd <= last_rd_nxt;
      op_wr   <= op_wr_nxt;
      ce_n    <= !((st_nxt == ST_READ) || (st_nxt == ST_WLOW) || (st_nxt == ST_WHOLD));
      oe_n    <= !(st_nxt == ST_READ);
      we_n    <= !(st_nxt == ST_WLOW);
      dq_oe   <= (st_nxt == ST_WLOW) || (st_nxt == ST_WHOLD);
    end
  end

endmodule

// File: rtl/sram_cyc_dpath.sv
module sram_cyc_dpath #(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              rd_capture,
  input  logic              wr_release,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [DATA_W-1:0] mem_dq_in,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              rsp_done
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_addr   <= '0;
      mem_dq_out <= '0;
      rsp_rdata  <= '0;
      rsp_done   <= 1'b0;
    end else begin
      if (accept) begin
        mem_addr   <= req_addr;
        mem_dq_out <= req_wdata;
      end
      if (rd_capture) rsp_rdata <= mem_dq_in;
      rsp_done <= rd_capture || wr_release;
    end
  end

endmodule

// File: rtl/sram_cyc_ctrl.sv
module sram_cyc_ctrl
  import sram_cyc_pkg::*;
#(
  parameter int CLK_NS        = 10,
  parameter int ADDR_W        = 17,
  parameter int DATA_W        = 8,
  parameter int T_CYCLE_NS    = 70,
  parameter int T_ADDR_ACC_NS = 70,
  parameter int T_CE_ACC_NS   = 70,
  parameter int T_OE_ACC_NS   = 35,
  parameter int T_WPULSE_NS   = 55,
  parameter int T_AW_NS       = 65,
  parameter int T_DSETUP_NS   = 30,
  parameter int T_AHOLD_NS    = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_done,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              mem_ce_n,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_in
);

  localparam int RD_CYC = nonzero(imax(imax(ns_to_cyc(T_ADDR_ACC_NS, CLK_NS),
                                            ns_to_cyc(T_CE_ACC_NS, CLK_NS)),
                                       ns_to_cyc(T_OE_ACC_NS, CLK_NS)));
  localparam int WL_CYC = nonzero(imax(imax(ns_to_cyc(T_WPULSE_NS, CLK_NS),
                                            ns_to_cyc(T_AW_NS, CLK_NS)),
                                       ns_to_cyc(T_DSETUP_NS, CLK_NS)));
  localparam int WH_CYC = nonzero(ns_to_cyc(T_AHOLD_NS, CLK_NS));
  localparam int CYC    = ns_to_cyc(T_CYCLE_NS, CLK_NS);
  localparam int RD_PAD = pad_of(CYC, RD_CYC);
  localparam int WR_PAD = pad_of(CYC, WL_CYC + WH_CYC);
  localparam int MAXC   = imax(imax(RD_CYC, WL_CYC), imax(WH_CYC, CYC));
  localparam int CNT_W  = $clog2(MAXC + 1);

  logic accept;
  logic rd_capture;
  logic wr_release;

  sram_cyc_seq #(
    .RD_CYC(RD_CYC), .WL_CYC(WL_CYC), .WH_CYC(WH_CYC),
    .RD_PAD(RD_PAD), .WR_PAD(WR_PAD), .CNT_W(CNT_W)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_ready (req_ready),
    .accept    (accept),
    .rd_capture(rd_capture),
    .wr_release(wr_release),
    .ce_n      (mem_ce_n),
    .oe_n      (mem_oe_n),
    .we_n      (mem_we_n),
    .dq_oe     (mem_dq_oe)
  );

  sram_cyc_dpath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dpath (
    .clk       (clk),
    .rst_n     (rst_n),
    .accept    (accept),
    .rd_capture(rd_capture),
    .wr_release(wr_release),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .mem_dq_in (mem_dq_in),
    .mem_addr  (mem_addr),
    .mem_dq_out(mem_dq_out),
    .rsp_rdata (rsp_rdata),
    .rsp_done  (rsp_done)
  );

endmodule

// File: rtl/sram_cyc_chk.sv
module sram_cyc_chk #(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 8,
  parameter int WL_CYC = 7,
  parameter int WH_CYC = 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              rsp_done,
  input logic              mem_ce_n,
  input logic              mem_oe_n,
  input logic              mem_we_n,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [DATA_W-1:0] mem_dq_out,
  input logic              mem_dq_oe
);

  int wl_run;
  int hold_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wl_run   <= 0;
      hold_run <= 0;
    end else begin
      wl_run   <= mem_we_n ? 0 : wl_run + 1;
      hold_run <= (mem_dq_oe && mem_we_n) ? hold_run + 1 : 0;
    end
  end

  a_r4_g_high_in_write: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> mem_oe_n);

  a_r4_w_pulse_len: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (wl_run == WL_CYC));

  a_r5_dq_within_e: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> (!mem_ce_n && mem_oe_n));

  a_r5_dq_steady: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |=> (!mem_dq_oe || $stable(mem_dq_out)));

  a_r5_hold_len: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_dq_oe) |-> (hold_run == WH_CYC));

  a_r6_addr_steady: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_ce_n |=> (mem_ce_n || $stable(mem_addr)));

  a_r7_busy_while_strobing: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_ce_n |-> !req_ready);

  a_r3_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> !rsp_done);

  a_r8_quiet_before_w: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_we_n) |-> ($past(mem_oe_n) && $past(!mem_dq_oe)));

endmodule

bind sram_cyc_ctrl sram_cyc_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .WL_CYC(WL_CYC), .WH_CYC(WH_CYC)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_ready (req_ready),
  .rsp_done  (rsp_done),
  .mem_ce_n  (mem_ce_n),
  .mem_oe_n  (mem_oe_n),
  .mem_we_n  (mem_we_n),
  .mem_addr  (mem_addr),
  .mem_dq_out(mem_dq_out),
  .mem_dq_oe (mem_dq_oe)
);

// File: tb/tb_sram_cyc_ctrl.sv
module tb_sram_cyc_ctrl;

  localparam int CLK = 4;
  localparam int TCYC = 85;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [16:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        rsp_done;
  logic [7:0]  rsp_rdata;
  logic        mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe;
  logic [16:0] mem_addr;
  logic [7:0]  mem_dq_out;
  logic [7:0]  mem_dq_in;

  int checks = 0;
  int errors = 0;
  bit prev_rd = 1'b0;

  logic [7:0] smem   [0:1023];
  logic [7:0] refmem [0:1023];

  always #2 clk = ~clk;

  sram_cyc_ctrl #(.CLK_NS(CLK), .T_CYCLE_NS(TCYC)) dut (.*);

  // behavioural memory: stores on the rising write strobe, reads while enabled
  always @(posedge mem_we_n)
    if (!mem_ce_n && mem_dq_oe) smem[mem_addr[9:0]] = mem_dq_out;
  assign mem_dq_in = (!mem_ce_n && !mem_oe_n) ? smem[mem_addr[9:0]] : 8'h00;

  function automatic int cyc_for(input int ns);
    int n = 0;
    while (n * CLK < ns) n++;
    return n;
  endfunction

  function automatic int mx(input int a, input int b);
    if (a > b) return a;
    return b;
  endfunction

  int E_RD, E_WL, E_WH, E_CYC;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // {write, addr[16:0], data[7:0]}
  localparam logic [25:0] VEC [9] = '{
    {1'b1, 17'h00000, 8'hA5},
    {1'b1, 17'h1FFFF, 8'h5A},
    {1'b0, 17'h00000, 8'h00},
    {1'b0, 17'h1FFFF, 8'h00},
    {1'b1, 17'h00155, 8'hC3},
    {1'b0, 17'h00155, 8'h00},
    {1'b0, 17'h002AA, 8'h00},
    {1'b1, 17'h002AA, 8'h3C},
    {1'b0, 17'h002AA, 8'h00}
  };

  task automatic do_op(input bit wr, input logic [16:0] a, input logic [7:0] d, input bit inject);
    int busy = 0, wl = 0, wh = 0, gl = 0, bad_g = 0, bad_a = 0, bad_d = 0, dn = 0;
    int first_w = -1;
    int exp_busy;
    bit turn = wr && prev_rd;
    logic [7:0] rd = 8'h00;
    @(negedge clk);
    chk(req_ready == 1'b1, "R7", "ready before request", int'(req_ready), 1);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    for (int c = 0; c < 200; c++) begin
      if (!req_ready) busy++;
      if (!mem_we_n) begin
        wl++;
        if (first_w < 0) first_w = c;
        if (!mem_oe_n) bad_g++;
      end
      if (mem_dq_oe && mem_we_n) wh++;
      if (mem_dq_oe && (mem_ce_n || mem_dq_out != d)) bad_d++;
      if (!mem_oe_n) gl++;
      if (!mem_ce_n && mem_addr != a) bad_a++;
      if (rsp_done) begin dn++; rd = rsp_rdata; end
      if (inject && c == 3) begin
        req_valid = 1'b1; req_write = 1'b1; req_addr = 17'h001CD; req_wdata = 8'h99;
      end
      if (inject && c == 4) req_valid = 1'b0;
      if (req_ready) break;
      @(negedge clk);
    end
    chk(bad_a == 0, "R6", "cycles with wrong address under E", bad_a, 0);
    chk(dn == 1, wr ? "R9" : "R3", "done pulses", dn, 1);
    if (wr) begin
      exp_busy = mx(E_WL + E_WH, E_CYC) + (turn ? 1 : 0);
      chk(wl == E_WL, "R4", "W low cycles", wl, E_WL);
      chk(bad_g == 0, "R4", "cycles with G low during W low", bad_g, 0);
      chk(wh == E_WH, "R5", "data hold cycles", wh, E_WH);
      chk(bad_d == 0, "R5", "bad data drive cycles", bad_d, 0);
      chk(first_w == (turn ? 1 : 0), "R8", "first W low cycle", first_w, turn ? 1 : 0);
      refmem[a[9:0]] = d;
      prev_rd = 1'b0;
    end else begin
      exp_busy = mx(E_RD, E_CYC);
      chk(gl == E_RD, "R2", "G low cycles", gl, E_RD);
      chk(wl == 0 && bad_d == 0, "R2", "write activity during read", wl + bad_d, 0);
      chk(rd == refmem[a[9:0]], "R3", "read data", int'(rd), int'(refmem[a[9:0]]));
      prev_rd = 1'b1;
    end
    chk(busy == exp_busy, "R7", "busy cycles", busy, exp_busy);
  endtask

  task automatic chk_idle(input string tag);
    chk(mem_ce_n && mem_oe_n && mem_we_n, "R1", {tag, " strobes high"},
        int'({mem_ce_n, mem_oe_n, mem_we_n}), 7);
    chk(!mem_dq_oe && req_ready && !rsp_done, "R1", {tag, " oe/ready/done"},
        int'({mem_dq_oe, req_ready, rsp_done}), 2);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL R7 watchdog: actual=timeout expected=completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 1024; i++) begin smem[i] = 8'h00; refmem[i] = 8'h00; end
    E_RD  = mx(cyc_for(70), cyc_for(35));
    E_WL  = mx(mx(cyc_for(55), cyc_for(65)), cyc_for(30));
    E_WH  = cyc_for(5);
    E_CYC = cyc_for(TCYC);
    repeat (3) @(negedge clk);
    chk_idle("R1 in reset");
    rst_n = 1'b1;
    @(negedge clk);
    chk_idle("R1 after reset");

    for (int i = 0; i < 9; i++)
      do_op(VEC[i][25], VEC[i][24:8], VEC[i][7:0], 1'b0);

    // R8: write right after write has no turnaround
    do_op(1'b1, 17'h00011, 8'h11, 1'b0);
    do_op(1'b1, 17'h00022, 8'h22, 1'b0);

    // R7: request offered while busy is dropped
    do_op(1'b1, 17'h000AB, 8'h77, 1'b1);
    do_op(1'b0, 17'h001CD, 8'h00, 1'b0);
    do_op(1'b0, 17'h000AB, 8'h00, 1'b0);

    // R1: reset in the middle of a write pulse abandons it
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 17'h00300; req_wdata = 8'hEE;
    @(negedge clk);
    req_valid = 1'b0;
    repeat (3) @(negedge clk);
    chk(!mem_we_n, "R4", "W low mid write", int'(mem_we_n), 0);
    rst_n = 1'b0;
    @(negedge clk);
    chk_idle("R1 mid-op reset");
    rst_n = 1'b1;
    @(negedge clk);
    chk_idle("R1 after mid-op reset");
    prev_rd = 1'b0;
    do_op(1'b0, 17'h00022, 8'h00, 1'b0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule